// File: doc/BRIEF.md
# Line Voltage Sag Detector

This block watches a stream of signed voltage samples and raises a sag flag when the line amplitude stays under a programmed level for a programmed number of consecutive half line cycles. Half-cycle edges are found inside the block from sign changes in the samples. A change of sign is accepted only when two samples in a row show the new sign, so a single noisy sample near zero does not add an edge. For each half cycle the block keeps the largest absolute sample. When the half cycle closes, that peak is compared with the level.

A small register port holds the half-cycle count, the level, a sticky status flag with a plain copy and a read-to-clear copy, and an interrupt enable. The active-low interrupt output follows the status flag while the enable is set. A control state machine has three states. OFF means detection is disabled. COUNT means below-level half cycles are being counted. SAGGED means a sag has been declared and further counting waits for the line to recover. Its transitions are ENABLE (OFF to COUNT, when both count and level become nonzero), DISABLE (any state to OFF, when either becomes zero), TRIP (COUNT to SAGGED, when the consecutive count reaches the period) and RECOVER (SAGGED to COUNT, on a half cycle whose peak reaches the level).

Top module: `sag_detector`

## Requirements
- R1: After reset every register reads 0, the status flag is clear, the interrupt enable is clear and `irq_n` is high.
- R2: Detection runs only while both the period register (address 0, bits [7:0]) and the level register (address 1, bits [22:0]) are nonzero. Otherwise no sag is flagged and the consecutive count is cleared.
- R3: A half cycle counts as below only when its peak absolute sample is strictly less than the level. A half cycle whose peak equals or exceeds the level resets the consecutive count to zero.
- R4: A sag is flagged when the number of consecutive below half cycles reaches the period value, for any period from 1 to 255.
- R5: A period value written while detection runs takes effect at once. Half cycles already counted under the old value still count toward the new one.
- R6: A half-cycle boundary is accepted on the second consecutive sample whose sign differs from the current polarity, with a zero sample treated as positive. A single opposite-sign sample creates no boundary.
- R7: The absolute value of the most negative sample code saturates to the largest positive magnitude.
- R8: A sag sets bit 19 of the status, which reads at address 2 and at address 3. A read of address 3 clears it, a read of address 2 leaves it set, and writes to either address are ignored. When a new sag arrives in the same cycle as a clear, the bit stays set.
- R9: `irq_n` is low exactly while the status bit is set and bit 19 of the enable register (address 4) is set.
- R10: After a sag, no new sag is flagged until at least one half cycle has peaked at or above the level.
- R11: Registers read back what was written, limited to their field widths: 8 bits for the period, 23 bits for the level and bit 19 for the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 24 | Two's complement voltage sample |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 3 clears the status) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| irq_n | output | 1 | Active-low sag interrupt |

## Verification
The bench builds the block with its default parameters: 24-bit samples, an 8-bit period and a 32-bit register word. With these values the full 255 half-cycle period can be reached in about a thousand samples, and the most negative code 0x800000 can be driven as is. Each half cycle is four samples of one sign, which lets the bench count closed half cycles exactly. It uses this to check the boundary between 254 and 255 half cycles, a level equal to the peak, a period rewritten in the middle of a run, a lone noise sample of the wrong sign, and the hold after a sag.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_COUNT  = 2'd1,
        ST_SAGGED = 2'd2
    } sag_state_e;

    localparam int ADR_PERIOD    = 0;
    localparam int ADR_LEVEL     = 1;
    localparam int ADR_STATUS    = 2;
    localparam int ADR_STATUS_RC = 3;
    localparam int ADR_ENABLE    = 4;

endpackage

// File: rtl/sag_halfcycle.sv
module sag_halfcycle #(
    parameter int SAMPLE_W = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_valid,
    input  logic [SAMPLE_W-1:0]   smp_data,
    output logic                  hc_done,
    output logic [SAMPLE_W-2:0]   hc_peak
);
    localparam int MAG_W = SAMPLE_W - 1;
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

    logic [SAMPLE_W-1:0] negated;
    logic [MAG_W-1:0]    mag;
    logic                sgn;

    logic                pol_q;
    logic                armed_q;
    logic [MAG_W-1:0]    pend_q;
    logic [MAG_W-1:0]    acc_q;

    logic [MAG_W-1:0]    acc_mag_max;
    logic [MAG_W-1:0]    acc_all_max;
    logic [MAG_W-1:0]    new_half_max;

    always_comb begin
        sgn     = smp_data[SAMPLE_W-1];
        negated = -smp_data;
        if (!sgn)
            mag = smp_data[MAG_W-1:0];
        else if (smp_data == MOST_NEG)
            mag = {MAG_W{1'b1}};
        else
            mag = negated[MAG_W-1:0];

        acc_mag_max  = (mag > acc_q) ? mag : acc_q;
        acc_all_max  = (pend_q > acc_mag_max) ? pend_q : acc_mag_max;
        new_half_max = (pend_q > mag) ? pend_q : mag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q   <= 1'b0;
            armed_q <= 1'b0;
            pend_q  <= '0;
            acc_q   <= '0;
            hc_done <= 1'b0;
            hc_peak <= '0;
        end else begin
            hc_done <= 1'b0;
            if (smp_valid) begin
                if (sgn == pol_q) begin
                    armed_q <= 1'b0;
                    acc_q   <= armed_q ? acc_all_max : acc_mag_max;
                end else if (!armed_q) begin
                    armed_q <= 1'b1;
                    pend_q  <= mag;
                end else begin
                    hc_done <= 1'b1;
                    hc_peak <= acc_q;
                    pol_q   <= sgn;
                    armed_q <= 1'b0;
                    acc_q   <= new_half_max;
                end
            end
        end
    end

endmodule

// File: rtl/sag_fsm.sv
module sag_fsm
    import sag_pkg::*;
#(
    parameter int PERIOD_W = 8,
    parameter int MAG_W    = 23
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sag_enabled,
    input  logic [PERIOD_W-1:0] period,
    input  logic [MAG_W-1:0]    level,
    input  logic                hc_done,
    input  logic [MAG_W-1:0]    hc_peak,
    output logic                sag_event,
    output sag_state_e          state
);
    sag_state_e            state_d;
    logic [PERIOD_W-1:0]   cnt_q;
    logic [PERIOD_W-1:0]   cnt_d;
    logic [PERIOD_W:0]     cnt_inc;
    logic                  below;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign below   = hc_peak < level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt_q <= '0;
        end else begin
            state <= state_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        state_d   = state;
        cnt_d     = cnt_q;
        sag_event = 1'b0;
        unique case (state)
            ST_OFF: begin
                cnt_d = '0;
                if (sag_enabled)
                    state_d = ST_COUNT;              // ENABLE
            end
            ST_COUNT: begin
                if (!sag_enabled) begin
                    state_d = ST_OFF;                // DISABLE
                    cnt_d   = '0;
                end else if (hc_done) begin
                    if (!below) begin
                        cnt_d = '0;
                    end else if (cnt_inc >= {1'b0, period}) begin
                        state_d   = ST_SAGGED;       // TRIP
                        sag_event = 1'b1;
                    end else begin
                        cnt_d = cnt_inc[PERIOD_W-1:0];
                    end
                end
            end
            ST_SAGGED: begin
                if (!sag_enabled) begin
                    state_d = ST_OFF;                // DISABLE
                    cnt_d   = '0;
                end else if (hc_done && !below) begin
                    state_d = ST_COUNT;              // RECOVER
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_OFF;
                cnt_d   = '0;
            end
        endcase
    end

endmodule

// File: rtl/sag_regs.sv
module sag_regs
    import sag_pkg::*;
#(
    parameter int PERIOD_W = 8,
    parameter int MAG_W    = 23,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3,
    parameter int FLAG_BIT = 19
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                sag_event,
    output logic [PERIOD_W-1:0] period_q,
    output logic [MAG_W-1:0]    level_q,
    output logic                status_q,
    output logic                en_q,
    output logic                sag_enabled,
    output logic                irq_n
);
    logic sel_period, sel_level, sel_status, sel_rc, sel_enable;
    logic rd_clear;

    assign sel_period = reg_addr == ADDR_W'(ADR_PERIOD);
    assign sel_level  = reg_addr == ADDR_W'(ADR_LEVEL);
    assign sel_status = reg_addr == ADDR_W'(ADR_STATUS);
    assign sel_rc     = reg_addr == ADDR_W'(ADR_STATUS_RC);
    assign sel_enable = reg_addr == ADDR_W'(ADR_ENABLE);
    assign rd_clear   = reg_rd && sel_rc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            level_q  <= '0;
            en_q     <= 1'b0;
        end else if (reg_wr) begin
            if (sel_period) period_q <= reg_wdata[PERIOD_W-1:0];
            if (sel_level)  level_q  <= reg_wdata[MAG_W-1:0];
            if (sel_enable) en_q     <= reg_wdata[FLAG_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status_q <= 1'b0;
        else if (sag_event)
            status_q <= 1'b1;
        else if (rd_clear)
            status_q <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_period)
            reg_rdata[PERIOD_W-1:0] = period_q;
        else if (sel_level)
            reg_rdata[MAG_W-1:0] = level_q;
        else if (sel_status || sel_rc)
            reg_rdata[FLAG_BIT] = status_q;
        else if (sel_enable)
            reg_rdata[FLAG_BIT] = en_q;
    end

    assign sag_enabled = (period_q != '0) && (level_q != '0);
    assign irq_n       = !(status_q && en_q);

endmodule

// File: rtl/sag_detector.sv
module sag_detector
    import sag_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int PERIOD_W = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3,
    parameter int FLAG_BIT = 19
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_n
);
    localparam int MAG_W = SAMPLE_W - 1;

    logic                hc_done;
    logic [MAG_W-1:0]    hc_peak;
    logic                sag_event;
    logic                sag_enabled;
    logic [PERIOD_W-1:0] period_q;
    logic [MAG_W-1:0]    level_q;
    logic                status_q;
    logic                en_q;
    sag_state_e          fsm_state;

    sag_halfcycle #(.SAMPLE_W(SAMPLE_W)) u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .hc_done  (hc_done),
        .hc_peak  (hc_peak)
    );

    sag_fsm #(.PERIOD_W(PERIOD_W), .MAG_W(MAG_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sag_enabled(sag_enabled),
        .period     (period_q),
        .level      (level_q),
        .hc_done    (hc_done),
        .hc_peak    (hc_peak),
        .sag_event  (sag_event),
        .state      (fsm_state)
    );

    sag_regs #(
        .PERIOD_W(PERIOD_W), .MAG_W(MAG_W), .DATA_W(DATA_W),
        .ADDR_W(ADDR_W), .FLAG_BIT(FLAG_BIT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .sag_event  (sag_event),
        .period_q   (period_q),
        .level_q    (level_q),
        .status_q   (status_q),
        .en_q       (en_q),
        .sag_enabled(sag_enabled),
        .irq_n      (irq_n)
    );

endmodule

// File: rtl/sag_detector_chk.sv
module sag_detector_chk
    import sag_pkg::*;
#(
    parameter int PERIOD_W = 8,
    parameter int MAG_W    = 23,
    parameter int ADDR_W   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_rd,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                irq_n,
    input logic                sag_event,
    input logic                hc_done,
    input logic                status_q,
    input logic [PERIOD_W-1:0] period_q,
    input logic [MAG_W-1:0]    level_q,
    input sag_state_e          fsm_state
);
    logic rc_read;
    assign rc_read = reg_rd && (reg_addr == ADDR_W'(ADR_STATUS_RC));

    // R8
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sag_event |=> status_q);

    // R8
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_read && !sag_event) |=> !status_q);

    // R9
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_read && !sag_event) |=> irq_n);

    // R2
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sag_event |-> (period_q != '0 && level_q != '0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_SAGGED) |-> !sag_event);

    // R6
    boundary_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hc_done |=> !hc_done);

endmodule

bind sag_detector sag_detector_chk #(
    .PERIOD_W(PERIOD_W), .MAG_W(SAMPLE_W - 1), .ADDR_W(ADDR_W)
) u_sag_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .irq_n    (irq_n),
    .sag_event(sag_event),
    .hc_done  (hc_done),
    .status_q (status_q),
    .period_q (period_q),
    .level_q  (level_q),
    .fsm_state(fsm_state)
);

// File: tb/test_sag_detector.sv
module test_sag_detector;
    localparam int CLK_PERIOD = 10;
    localparam int HIGH_MAG   = 32'h7FFFFF;
    localparam int BIT        = 19;

    typedef struct packed {
        logic [7:0]  per;
        logic [22:0] lvl;
        logic [22:0] mag;
        logic [8:0]  halves;
        logic        exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'd3,   23'd1000, 23'd500,  9'd3,   1'b1},  // R4
        '{8'd3,   23'd1000, 23'd500,  9'd2,   1'b0},  // R4
        '{8'd3,   23'd1000, 23'd1000, 9'd5,   1'b0},  // R3 equal
        '{8'd3,   23'd1000, 23'd999,  9'd3,   1'b1},  // R3
        '{8'd0,   23'd1000, 23'd10,   9'd5,   1'b0},  // R2
        '{8'd5,   23'd0,    23'd10,   9'd8,   1'b0},  // R2
        '{8'd1,   23'd1000, 23'd1,    9'd1,   1'b1},  // R4
        '{8'd255, 23'd1000, 23'd500,  9'd255, 1'b1},  // R4
        '{8'd255, 23'd1000, 23'd500,  9'd254, 1'b0},  // R4
        '{8'd2,   23'd1000, 23'd1500, 9'd6,   1'b0}   // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_data = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_n;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  neg      = 1'b0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sag_detector i_sag_detector (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic put(input int v);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 24'(v);
    endtask

    task automatic half(input int mag);
        neg = ~neg;
        for (int i = 0; i < 4; i++)
            put(neg ? -mag : ((mag > HIGH_MAG) ? HIGH_MAG : mag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b0;
        end
    endtask

    task automatic setup(input int per, input int lvl);
        logic [31:0] d;
        idle(1);
        wr(3'd1, 32'd0);
        wr(3'd0, 32'(per));
        wr(3'd1, 32'(lvl));
        half(HIGH_MAG);
        half(HIGH_MAG);
        idle(3);
        rd(3'd3, d);
    endtask

    task automatic status(input string req, input logic exp);
        logic [31:0] d;
        idle(3);
        rd(3'd2, d);
        check(req, 32'(d[BIT]), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq_n", 32'(irq_n), 32'd1);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check("R1 register", d, 32'd0);
        end

        // R11: readback masks
        wr(3'd0, 32'hFFFF_FF5A);
        rd(3'd0, d);
        check("R11 period", d, 32'h5A);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, d);
        check("R11 level", d, 32'h7F_FFFF);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d);
        check("R11 enable", d, 32'h0008_0000);
        wr(3'd4, 32'd0);

        // R2 R3 R4: table of vectors
        for (int v = 0; v < 10; v++) begin
            setup(int'(VECS[v].per), int'(VECS[v].lvl));
            for (int h = 0; h < int'(VECS[v].halves); h++)
                half(int'(VECS[v].mag));
            half(HIGH_MAG);
            status("R2/R3/R4 vector", VECS[v].exp);
        end

        // R7: most negative code saturates, not below max level
        setup(1, HIGH_MAG);
        for (int h = 0; h < 4; h++) half(32'h80_0000);
        half(HIGH_MAG);
        status("R7 saturation", 1'b0);

        // R6: single opposite-sign sample is not a boundary
        setup(1, 1000);
        neg = ~neg;
        put(neg ? -2000 : 2000);
        put(neg ? 5 : -5);
        put(neg ? -2000 : 2000);
        put(neg ? -2000 : 2000);
        half(2000);
        status("R6 hysteresis", 1'b0);

        // R10: hold after a sag
        setup(2, 1000);
        half(100); half(100); half(100);
        status("R10 first sag", 1'b1);
        rd(3'd3, d);
        half(100); half(100); half(100);
        status("R10 hold", 1'b0);
        half(HIGH_MAG); half(100); half(100); half(100);
        status("R10 after recover", 1'b1);

        // R5: period rewritten mid-run
        setup(4, 1000);
        half(100); half(100);
        idle(1);
        wr(3'd0, 32'd2);
        half(100);
        half(HIGH_MAG);
        status("R5 immediate period", 1'b1);

        // R9: interrupt gating
        idle(2);
        check("R9 enable off", 32'(irq_n), 32'd1);
        wr(3'd4, 32'h0008_0000);
        check("R9 enable on", 32'(irq_n), 32'd0);
        wr(3'd4, 32'd0);
        check("R9 enable cleared", 32'(irq_n), 32'd1);
        wr(3'd4, 32'h0008_0000);

        // R8: plain read keeps, writes ignored, read-to-clear clears
        rd(3'd2, d);
        check("R8 plain read", 32'(d[BIT]), 32'd1);
        wr(3'd2, 32'd0);
        wr(3'd3, 32'd0);
        rd(3'd2, d);
        check("R8 write ignored", 32'(d[BIT]), 32'd1);
        check("R9 irq asserted", 32'(irq_n), 32'd0);
        rd(3'd3, d);
        check("R8 rc read value", 32'(d[BIT]), 32'd1);
        rd(3'd2, d);
        check("R8 cleared", 32'(d[BIT]), 32'd0);
        check("R9 irq released", 32'(irq_n), 32'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule